// File: doc/BRIEF.md
# Background Memory Scrubber

This block walks every word of a SECDED-protected single-port memory in the background, so that soft errors are removed before a second upset in the same word makes them uncorrectable. After a programmable number of idle cycles it reads one 72-bit codeword from the configured address window and checks it. A word with a single-bit fault is written back in corrected form. A word with a double-bit fault is left unchanged, and its address is logged. A clean word is never rewritten.

The block sits between a functional master and the memory. The master always has priority. A scrub read that loses arbitration is retried at the same address. The read-modify-write of one word is atomic: the write-back goes out in the cycle that follows the read, and for that one cycle the functional master gets no grant. Software sees two saturating event counters, the address of the last uncorrectable word, and a sticky interrupt flag. The counters and the flag each have a write-one-to-clear pulse input.

Top module: `scrub_engine`

## Requirements
- R1: Scrub reads visit the addresses `cfg_lo`, `cfg_lo`+1, …, `cfg_hi` in order, then wrap to `cfg_lo`. If the next address lies outside the window when a read is issued, the read uses `cfg_lo`.
- R2: The codeword holds data in bits [63:0] and check bits in [71:64]. Data bit j takes the Hamming position that is the (j+1)-th integer from 3 upward that is not a power of two. Check bit k (k<7) is the XOR of the data bits whose position has bit k set. Bit 71 is the XOR of bits [70:0]. Memory reads return data one cycle after the read. When a scrub read finds a single-bit error in any of the 72 bits, the cycle that follows the read carries a write to the same address. The written value is the re-encoded codeword of the corrected data.
- R3: A scrub read of a codeword with no error produces no write.
- R4: A scrub read of a double-bit error produces no write. It increments the uncorrectable counter, stores the address in `last_ue_addr` and sets `irq`.
- R5: While `fn_req` is high outside a write-back cycle, the functional master is granted and no scrub read is issued. A blocked scrub read is retried later at the same address.
- R6: With `cfg_interval` = N > 0, each scrub access is followed by N idle cycles before the next read request. Without contention, consecutive scrub reads are therefore N+2 cycles apart. With N = 0, no new scrub read starts.
- R7: In a write-back cycle `fn_gnt` is low. A functional write that is held there lands in the next cycle, after the correction.
- R8: Correctable and uncorrectable events are counted separately. Both counters reset to zero and saturate at 2^CW−1.
- R9: A pulse on `clr_ce` or `clr_ue` zeroes the matching counter at the next edge and leaves the other counter unchanged.
- R10: `irq` resets low, stays high after an uncorrectable event until `clr_irq` is pulsed, and is cleared by that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_interval | input | IW | Idle cycles between scrub accesses; 0 stops scrubbing |
| cfg_lo | input | AW | First address of the scrub window |
| cfg_hi | input | AW | Last address of the scrub window |
| clr_ce | input | 1 | Write-one-to-clear pulse for the correctable counter |
| clr_ue | input | 1 | Write-one-to-clear pulse for the uncorrectable counter |
| clr_irq | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| fn_req | input | 1 | Functional access request |
| fn_we | input | 1 | Functional access is a write |
| fn_addr | input | AW | Functional address |
| fn_wdata | input | 72 | Functional write codeword |
| fn_gnt | output | 1 | Functional access is issued this cycle |
| fn_rdata | output | 72 | Read data returned to the functional master |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 72 | Memory write codeword |
| mem_rdata | input | 72 | Memory read codeword, one cycle after the read |
| ce_count | output | CW | Saturating count of corrected words |
| ue_count | output | CW | Saturating count of uncorrectable words |
| last_ue_addr | output | AW | Address of the most recent uncorrectable word |
| irq | output | 1 | Sticky uncorrectable-error flag |

## Verification
Arbitration and write-back can meet in one cycle: a functional request that arrives in the cycle after a scrub read of a faulty word collides with that word's correction. The bench waits until it sees such a scrub read at the memory port. It then raises a functional write to the same address at the next edge. It checks that this cycle carries the scrub write with `fn_gnt` low. It also checks that the functional data lands one cycle later and is not overwritten. Counter clears are also pulsed while the other counter and the flag hold values, to show that the clears are independent.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  localparam int DW  = 64;
  localparam int CBW = 8;
  localparam int CWW = DW + CBW;

  typedef enum logic [1:0] {CHK_OK = 2'd0, CHK_CE = 2'd1, CHK_UE = 2'd2} chk_e;

  // Hamming position of data bit j: skips 1, 2 and every later power of two
  function automatic logic [6:0] data_pos(input int j);
    int p;
    p = 2;
    for (int i = 0; i <= j; i++) begin
      p++;
      if ((p & (p - 1)) == 0) p++;
    end
    return 7'(p);
  endfunction

  function automatic logic [CWW-1:0] ecc_encode(input logic [DW-1:0] d);
    logic [6:0] c;
    logic [6:0] pos;
    c = '0;
    for (int j = 0; j < DW; j++) begin
      pos = data_pos(j);
      for (int k = 0; k < 7; k++)
        if (pos[k]) c[k] = c[k] ^ d[j];
    end
    return {(^d) ^ (^c), c, d};
  endfunction

  function automatic logic [6:0] ecc_syndrome(input logic [CWW-1:0] cw);
    logic [CWW-1:0] ref_cw;
    ref_cw = ecc_encode(cw[DW-1:0]);
    return ref_cw[DW+6:DW] ^ cw[DW+6:DW];
  endfunction

  function automatic chk_e ecc_classify(input logic [CWW-1:0] cw);
    logic [6:0] s;
    logic       odd;
    s   = ecc_syndrome(cw);
    odd = ^cw;
    if (!odd && s == '0)             return CHK_OK;
    if (!odd)                         return CHK_UE;
    if (s <= 7'd71)                   return CHK_CE;
    return CHK_UE;
  endfunction

  // Corrected codeword, re-encoded from the repaired data
  function automatic logic [CWW-1:0] ecc_fix(input logic [CWW-1:0] cw);
    logic [6:0]    s;
    logic [DW-1:0] d;
    s = ecc_syndrome(cw);
    d = cw[DW-1:0];
    for (int j = 0; j < DW; j++)
      if (data_pos(j) == s) d[j] = ~d[j];
    return ecc_encode(d);
  endfunction

endpackage

// File: rtl/scrub_decode.sv
module scrub_decode
  import scrub_pkg::*;
(
  input  logic [CWW-1:0] cw,
  output chk_e           kind,
  output logic [CWW-1:0] fixed_cw
);
  always_comb begin
    kind     = ecc_classify(cw);
    fixed_cw = ecc_fix(cw);
  end
endmodule

// File: rtl/scrub_timer.sv
module scrub_timer #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [IW-1:0] interval,
  output logic          fire
);
  logic [IW-1:0] cnt;

  assign fire = run && (interval != '0) && (cnt >= interval - IW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt <= '0;
    else if (!run || fire || interval == '0)   cnt <= '0;
    else                                       cnt <= cnt + IW'(1);
  end
endmodule

// File: rtl/scrub_satcnt.sv
module scrub_satcnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (inc && cnt != TOP)   cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
  import scrub_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 16,
  parameter int IW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IW-1:0]  cfg_interval,
  input  logic [AW-1:0]  cfg_lo,
  input  logic [AW-1:0]  cfg_hi,
  input  logic           clr_ce,
  input  logic           clr_ue,
  input  logic           clr_irq,
  input  logic           fn_req,
  input  logic           fn_we,
  input  logic [AW-1:0]  fn_addr,
  input  logic [CWW-1:0] fn_wdata,
  output logic           fn_gnt,
  output logic [CWW-1:0] fn_rdata,
  output logic           mem_en,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [CWW-1:0] mem_wdata,
  input  logic [CWW-1:0] mem_rdata,
  output logic [CW-1:0]  ce_count,
  output logic [CW-1:0]  ue_count,
  output logic [AW-1:0]  last_ue_addr,
  output logic           irq
);
  typedef enum logic [1:0] {S_WAIT, S_PEND, S_RESP} st_e;

  st_e            st;
  logic [AW-1:0]  cur;
  logic [AW-1:0]  rd_addr;
  logic           fire;
  chk_e           kind;
  logic [CWW-1:0] fixed_cw;

  // Named internal events for the checker
  logic scr_pend, scr_rd, scr_wr, ce_ev, ue_ev;

  assign rd_addr  = (cur < cfg_lo || cur > cfg_hi) ? cfg_lo : cur;
  assign scr_pend = (st == S_PEND);
  assign scr_rd   = scr_pend && !fn_req;
  assign ce_ev    = (st == S_RESP) && (kind == CHK_CE);
  assign ue_ev    = (st == S_RESP) && (kind == CHK_UE);
  assign scr_wr   = ce_ev;

  assign fn_gnt    = fn_req && !scr_wr;
  assign mem_en    = fn_gnt || scr_rd || scr_wr;
  assign mem_we    = fn_gnt ? fn_we : scr_wr;
  assign mem_addr  = fn_gnt ? fn_addr : ((st == S_RESP) ? cur : rd_addr);
  assign mem_wdata = fn_gnt ? fn_wdata : fixed_cw;
  assign fn_rdata  = mem_rdata;

  scrub_timer #(.IW(IW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st == S_WAIT),
    .interval(cfg_interval), .fire(fire)
  );

  scrub_decode u_dec (.cw(mem_rdata), .kind(kind), .fixed_cw(fixed_cw));

  scrub_satcnt #(.CW(CW)) u_ce_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ce_ev), .clr(clr_ce), .cnt(ce_count)
  );
  scrub_satcnt #(.CW(CW)) u_ue_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ue_ev), .clr(clr_ue), .cnt(ue_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_WAIT;
      cur <= '0;
    end else begin
      case (st)
        S_WAIT: if (fire) st <= S_PEND;
        S_PEND: if (scr_rd) begin
          st  <= S_RESP;
          cur <= rd_addr;
        end
        S_RESP: begin
          st  <= S_WAIT;
          cur <= (cur >= cfg_hi) ? cfg_lo : cur + AW'(1);
        end
        default: st <= S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ue_addr <= '0;
      irq          <= 1'b0;
    end else begin
      if (ue_ev) last_ue_addr <= cur;
      irq <= ue_ev || (irq && !clr_irq);
    end
  end
endmodule

// File: rtl/scrub_engine_chk.sv
module scrub_engine_chk
  import scrub_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 16,
  parameter int IW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fn_req,
  input logic           fn_gnt,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [CWW-1:0] mem_wdata,
  input logic           scr_rd,
  input logic           scr_wr,
  input logic           scr_pend,
  input logic [IW-1:0]  cfg_interval,
  input logic [CW-1:0]  ce_count,
  input logic [CW-1:0]  ue_count,
  input logic           clr_ce,
  input logic           clr_ue,
  input logic           irq,
  input logic           clr_irq
);
  localparam logic [CW-1:0] TOP = '1;

  p_fn_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fn_req |-> !scr_rd);

  p_wb_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scr_wr |-> ($past(scr_rd) && mem_addr == $past(mem_addr)));

  p_no_fn_in_rmw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scr_wr |-> (!fn_gnt && mem_we));

  p_wb_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scr_wr |-> (ecc_classify(mem_wdata) == CHK_OK));

  p_off_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_interval == '0 && !scr_pend) |=> !scr_rd);

  p_ce_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_count == TOP && !clr_ce) |=> ce_count == TOP);

  p_ue_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_count == TOP && !clr_ue) |=> ue_count == TOP);

  p_ce_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ce |=> ce_count == '0);

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_irq) |=> irq);
endmodule

bind scrub_engine scrub_engine_chk #(.AW(AW), .CW(CW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fn_req(fn_req), .fn_gnt(fn_gnt),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .scr_rd(scr_rd), .scr_wr(scr_wr), .scr_pend(scr_pend),
  .cfg_interval(cfg_interval), .ce_count(ce_count), .ue_count(ue_count),
  .clr_ce(clr_ce), .clr_ue(clr_ue), .irq(irq), .clr_irq(clr_irq)
);

// File: tb/tb_scrub_engine.sv
module tb_scrub_engine;
  localparam int AW = 4;
  localparam int CW = 4;
  localparam int IW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [IW-1:0] cfg_interval = '0;
  logic [AW-1:0] cfg_lo = 4'd2, cfg_hi = 4'd5;
  logic clr_ce = 0, clr_ue = 0, clr_irq = 0;
  logic fn_req = 0, fn_we = 0;
  logic [AW-1:0] fn_addr = '0;
  logic [71:0] fn_wdata = '0;
  logic fn_gnt, mem_en, mem_we, irq;
  logic [71:0] fn_rdata, mem_wdata;
  logic [71:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr, last_ue_addr;
  logic [CW-1:0] ce_count, ue_count;

  scrub_engine #(.AW(AW), .CW(CW), .IW(IW)) dut (.*);

  logic [71:0] mem [DEPTH];
  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end

  int total = 0, bad = 0, cyc = 0;
  int n_rd = 0, last_rd = 0, gap_exp = 0;
  bit chk_gap = 0;
  logic [AW-1:0] exp_rd = 4'd2;
  logic [AW+71:0] exp_wr [$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Bench encoder: build the positional Hamming word, then gather parities
  function automatic logic [71:0] benc(input logic [63:0] d);
    logic [127:0] v;
    logic [6:0] c;
    int di;
    v = '0; di = 0; c = '0;
    for (int p = 1; p < 72; p++)
      if ((p & (p - 1)) != 0) begin v[p] = d[di]; di++; end
    for (int p = 1; p < 72; p++)
      for (int k = 0; k < 7; k++)
        if (p[k]) c[k] ^= v[p];
    return {(^d) ^ (^c), c, d};
  endfunction

  task automatic push_wr(input logic [AW-1:0] a, input logic [71:0] w);
    exp_wr.push_back({a, w});
  endtask

  function automatic logic [AW-1:0] next_in(input logic [AW-1:0] a);
    return (a >= cfg_hi) ? cfg_lo : a + AW'(1);
  endfunction

  // Monitor: scrub reads follow the window (R1), gaps (R6), write-backs scored (R2/R3)
  always @(negedge clk) begin
    cyc++;
    if (rst_n && mem_en && !fn_gnt && !mem_we) begin
      check(mem_addr == exp_rd, "R1", "scrub read address", mem_addr, exp_rd);
      if (chk_gap && last_rd != 0)
        check(cyc - last_rd == gap_exp, "R6", "read spacing", cyc - last_rd, gap_exp);
      last_rd = cyc;
      exp_rd = next_in(exp_rd);
      n_rd++;
    end
    if (rst_n && mem_en && !fn_gnt && mem_we) begin
      if (exp_wr.size() == 0)
        check(0, "R3", "unexpected write-back addr", mem_addr, 0);
      else begin
        logic [AW+71:0] e;
        e = exp_wr.pop_front();
        check({mem_addr, mem_wdata} == e, "R2", "write-back", mem_wdata, e[71:0]);
      end
    end
  end

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    check(0, "R1", "watchdog expired", cyc, 0);
    summary();
  end

  task automatic pulse(ref logic s);
    @(posedge clk); #1 s = 1;
    @(posedge clk); #1 s = 0;
    @(negedge clk);
  endtask

  task automatic quiesce;
    cfg_interval = '0;
    repeat (10) @(negedge clk);
  endtask

  task automatic set_window(input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    cfg_lo = lo; cfg_hi = hi;
    if (exp_rd < lo || exp_rd > hi) exp_rd = lo;
    last_rd = 0;
  endtask

  initial begin
    logic [71:0] c3, c4, c5, c6, alt;
    int n0;
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ce_count == 0 && ue_count == 0, "R8", "counters after reset", {ce_count, ue_count}, 0);
    check(irq == 0, "R10", "irq after reset", irq, 0);
    check(mem_en == 0, "R6", "idle with interval 0", mem_en, 0);

    // Mixed faults in window 2..5
    c3 = benc(64'h0123_4567_89ab_cdef);
    c4 = benc(64'hdead_beef_0000_1111);
    c5 = benc(64'h5555_aaaa_3c3c_c3c3);
    mem[2] = benc(64'h42);
    mem[3] = c3 ^ (72'd1 << 10);
    mem[4] = c4 ^ 72'h3;
    mem[5] = c5 ^ (72'd1 << 68);
    push_wr(4'd3, c3);
    push_wr(4'd5, c5);
    gap_exp = 5; chk_gap = 1;
    cfg_interval = 8'd3;
    wait (n_rd >= 8);
    cfg_interval = '0; chk_gap = 0;
    repeat (3) @(negedge clk);
    check(ce_count == 2, "R8", "ce after two sweeps", ce_count, 2);
    check(ue_count == 2, "R4", "ue after two sweeps", ue_count, 2);
    check(last_ue_addr == 4, "R4", "last ue address", last_ue_addr, 4);
    check(irq == 1, "R10", "irq set", irq, 1);
    check(mem[4] == (c4 ^ 72'h3), "R4", "double-error word untouched", mem[4][31:0], c4[31:0] ^ 3);
    check(mem[3] == c3 && mem[5] == c5, "R2", "words corrected", mem[3][31:0], c3[31:0]);
    check(mem[2] == benc(64'h42), "R3", "clean word untouched", mem[2][31:0], 32'h42);

    // Clears
    pulse(clr_ce);
    check(ce_count == 0 && ue_count == 2, "R9", "clear ce only", {ce_count, ue_count}, 2);
    check(irq == 1, "R10", "irq holds without clear", irq, 1);
    pulse(clr_irq);
    check(irq == 0, "R10", "irq cleared", irq, 1'b0);
    pulse(clr_ue);
    check(ue_count == 0, "R9", "clear ue", ue_count, 0);

    // Interval zero stops scrubbing
    n0 = n_rd;
    repeat (60) @(negedge clk);
    check(n_rd == n0, "R6", "no reads with interval 0", n_rd, n0);

    // Saturation: full window, every word single-faulted
    set_window(4'd0, 4'd15);
    begin
      logic [AW-1:0] a;
      a = exp_rd;
      for (int i = 0; i < DEPTH; i++) begin
        logic [71:0] g;
        g = benc(64'h1000 + 64'(a));
        mem[a] = g ^ (72'd1 << ((int'(a) * 5) % 72));
        push_wr(a, g);
        a = a + AW'(1);
      end
    end
    n0 = n_rd;
    cfg_interval = 8'd1;
    wait (n_rd >= n0 + 16);
    cfg_interval = '0;
    repeat (3) @(negedge clk);
    check(ce_count == 4'hF, "R8", "ce saturates", ce_count, 4'hF);
    check(exp_wr.size() == 0, "R2", "all corrections seen", exp_wr.size(), 0);

    // Arbitration and atomic write-back
    quiesce();
    set_window(4'd6, 4'd6);
    c6 = benc(64'hfeed_f00d);
    alt = benc(64'h7777);
    mem[6] = c6 ^ (72'd1 << 40);
    fn_req = 1; fn_we = 0; fn_addr = 4'd0;
    cfg_interval = 8'd2;
    n0 = n_rd;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 39) check(fn_gnt == 1, "R5", "functional granted", fn_gnt, 1);
    end
    check(n_rd == n0, "R5", "scrub blocked by functional", n_rd, n0);
    push_wr(4'd6, c6);
    @(posedge clk); #1 fn_req = 0;
    wait (n_rd == n0 + 1);
    @(posedge clk); #1
    fn_req = 1; fn_we = 1; fn_addr = 4'd6; fn_wdata = alt;
    @(negedge clk);
    check(!fn_gnt && mem_we && mem_addr == 6, "R7", "write-back holds port", fn_gnt, 0);
    @(negedge clk);
    check(fn_gnt == 1, "R7", "functional follows", fn_gnt, 1);
    @(posedge clk); #1 fn_req = 0; fn_we = 0;
    @(negedge clk);
    check(mem[6] == alt, "R7", "functional write lands last", mem[6][31:0], alt[31:0]);
    repeat (20) @(negedge clk);
    quiesce();
    check(exp_wr.size() == 0, "R3", "no extra write-backs", exp_wr.size(), 0);
    check(ce_count == 4'hF, "R8", "ce stays saturated", ce_count, 4'hF);
    summary();
  end
endmodule